// File: doc/BRIEF.md
# Serial Transceiver Reset Sequencer

This block brings a multi-channel serial transceiver out of reset after power-up, and again whenever software asks for it. It keeps every PLL reset and datapath reset asserted until all channels report good power. It then waits an optional settling interval, which lets the reference clocks become stable. After that it runs one full reset of the transmit side and the receive side, with no request from the user.

Each direction has its own sequencer. A sequencer first pulses its PLL reset and waits for lock. It then releases the datapath reset and waits for the user clocking logic to report running clocks. Next it raises user-ready and waits for every primitive to report reset complete. Finally it raises done. If that direction bypasses its elastic buffer, the block sends a one-cycle start pulse to the alignment logic at the moment done rises.

Any wait that runs past a timeout restarts the sequence at the PLL reset. After completion, loss of lock on any channel drops done. The sequencer then stays idle until the user requests a new reset, and it accepts such a request only once the power-up reset has finished for both directions. All status inputs pass through two-flop synchronisers before the sequencers use them.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While the synchronised power-good of any channel is low, both PLL resets and both datapath resets are high, and both done outputs and both user-ready outputs are low.
- R2: With the settling delay enabled, the PLL resets stay high for at least PG_DLY_CYC cycles after the last power-good input goes high.
- R3: After power is good, both directions complete a reset and raise their done outputs with no user request.
- R4: The datapath reset of a direction is released only after its PLL reset has been released and all of its PLL lock inputs are high.
- R5: User-ready of a direction rises only while that direction's user-clock-active input (synchronised) is high. While that input is low, user-ready and done stay low.
- R6: Done of a direction rises only after the reset-done inputs of all channels of that direction are high. Done implies user-ready high and datapath reset low.
- R7: When the BYPASS parameter of a direction is 1, that direction's start output is high for exactly one cycle: the cycle in which done rises. It pulses once per completed sequence.
- R8: After completion, a low lock input on any channel of a direction drops that direction's done. The PLL reset stays low and done stays low until a new request for that direction arrives, even if lock returns.
- R9: Reset requests are ignored until both done outputs have been high together once. After that, a request restarts only the requested direction, and the other direction's done stays high.
- R10: If a wait state lasts TMO_CYC cycles without its condition being met, the direction reasserts its PLL reset and starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | NCH | Per-channel power-good, asynchronous |
| tx_lock_i | input | NCH | Lock of the PLL feeding each transmit channel, asynchronous |
| rx_lock_i | input | NCH | Lock of the PLL feeding each receive channel, asynchronous |
| tx_rdone_i | input | NCH | Transmit reset complete, per channel, asynchronous |
| rx_rdone_i | input | NCH | Receive reset complete, per channel, asynchronous |
| tx_uclk_act_i | input | 1 | Transmit user clocks running |
| rx_uclk_act_i | input | 1 | Receive user clocks running |
| tx_rst_req_i | input | 1 | Request a transmit reset |
| rx_rst_req_i | input | 1 | Request a receive reset |
| tx_pll_rst_o | output | 1 | Transmit PLL reset |
| tx_dp_rst_o | output | 1 | Transmit datapath reset |
| tx_usr_rdy_o | output | 1 | Transmit user-ready |
| tx_done_o | output | 1 | Transmit reset complete |
| tx_byp_start_o | output | 1 | Transmit buffer-bypass alignment start pulse |
| rx_pll_rst_o | output | 1 | Receive PLL reset |
| rx_dp_rst_o | output | 1 | Receive datapath reset |
| rx_usr_rdy_o | output | 1 | Receive user-ready |
| rx_done_o | output | 1 | Receive reset complete |
| rx_byp_start_o | output | 1 | Receive buffer-bypass alignment start pulse |

## Verification
The assertions check the cycle-level ordering rules on every cycle: resets are held before power is settled, the datapath is released only after the PLL, user-ready rises only when clocks are reported active, done implies ready with the datapath released, and the bypass pulse coincides with the rise of done. Some behaviours depend on what the design does not do over long stretches, and only the bench's scenarios can show them. These are the minimum length of the settling delay, the absence of a restart after lock loss, requests ignored before power-up completes, the independence of the two directions and the timeout restart. The bench sweeps every incomplete power-good pattern and models the PLLs and primitives as small handshake counters.

// File: rtl/xcvr_rst_pkg.sv
package xcvr_rst_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_PLL_RST,
        ST_WAIT_LOCK,
        ST_WAIT_UCLK,
        ST_WAIT_DONE,
        ST_DONE,
        ST_LOST
    } seq_state_e;

    typedef struct packed {
        logic pll_rst;
        logic dp_rst;
        logic usr_rdy;
        logic done;
        logic byp_start;
    } seq_out_t;

    function automatic seq_out_t decode_state(seq_state_e s, logic byp);
        seq_out_t o;
        o.pll_rst   = (s == ST_HOLD) || (s == ST_PLL_RST);
        o.dp_rst    = o.pll_rst || (s == ST_WAIT_LOCK);
        o.usr_rdy   = (s == ST_WAIT_DONE) || (s == ST_DONE) || (s == ST_LOST);
        o.done      = (s == ST_DONE);
        o.byp_start = byp;
        return o;
    endfunction

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/xrs_pg_hold.sv
module xrs_pg_hold #(
    parameter int NCH     = 4,
    parameter bit DLY_EN  = 1'b1,
    parameter int DLY_CYC = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pg_s,
    output logic           pg_ok
);
    logic pg_all;
    assign pg_all = &pg_s;

    generate
        if (DLY_EN) begin : g_delay
            localparam int DW = $clog2(DLY_CYC + 1);
            logic [DW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt   <= '0;
                    pg_ok <= 1'b0;
                end else if (!pg_ok) begin
                    if (!pg_all) begin
                        cnt <= '0;
                    end else if (cnt == DW'(DLY_CYC - 1)) begin
                        pg_ok <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end else begin : g_direct
            always_ff @(posedge clk) begin
                if (rst) begin
                    pg_ok <= 1'b0;
                end else if (pg_all) begin
                    pg_ok <= 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/xrs_dir_seq.sv
module xrs_dir_seq
    import xcvr_rst_pkg::*;
#(
    parameter int TMO_CYC     = 1000,
    parameter int PLL_RST_CYC = 8,
    parameter bit BYPASS      = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     req,
    input  logic     lock_ok,
    input  logic     uclk_ok,
    input  logic     rdone_ok,
    output seq_out_t out
);
    localparam int MAXC = (TMO_CYC > PLL_RST_CYC) ? TMO_CYC : PLL_RST_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic          byp_q;
    logic          tmo;

    assign tmo = (cnt == CW'(TMO_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HOLD;
            cnt   <= '0;
            byp_q <= 1'b0;
        end else begin
            byp_q <= 1'b0;
            cnt   <= cnt + 1'b1;
            if (req && state != ST_HOLD) begin
                state <= ST_PLL_RST;
                cnt   <= '0;
            end else begin
                case (state)
                    ST_HOLD: begin
                        cnt <= '0;
                        if (start) state <= ST_PLL_RST;
                    end
                    ST_PLL_RST: begin
                        if (cnt == CW'(PLL_RST_CYC - 1)) begin
                            state <= ST_WAIT_LOCK;
                            cnt   <= '0;
                        end
                    end
                    ST_WAIT_LOCK: begin
                        if (lock_ok) begin
                            state <= ST_WAIT_UCLK;
                            cnt   <= '0;
                        end else if (tmo) begin
                            state <= ST_PLL_RST;
                            cnt   <= '0;
                        end
                    end
                    ST_WAIT_UCLK: begin
                        if (uclk_ok) begin
                            state <= ST_WAIT_DONE;
                            cnt   <= '0;
                        end else if (tmo) begin
                            state <= ST_PLL_RST;
                            cnt   <= '0;
                        end
                    end
                    ST_WAIT_DONE: begin
                        if (rdone_ok) begin
                            state <= ST_DONE;
                            cnt   <= '0;
                            byp_q <= BYPASS;
                        end else if (tmo) begin
                            state <= ST_PLL_RST;
                            cnt   <= '0;
                        end
                    end
                    ST_DONE: begin
                        cnt <= '0;
                        if (!lock_ok) state <= ST_LOST;
                    end
                    default: begin
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

    assign out = decode_state(state, byp_q);
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
    import xcvr_rst_pkg::*;
#(
    parameter int NCH         = 4,
    parameter bit PG_DLY_EN   = 1'b1,
    parameter int PG_DLY_CYC  = 64,
    parameter int TMO_CYC     = 1000,
    parameter int PLL_RST_CYC = 8,
    parameter bit TX_BYPASS   = 1'b1,
    parameter bit RX_BYPASS   = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pwr_good_i,
    input  logic [NCH-1:0] tx_lock_i,
    input  logic [NCH-1:0] rx_lock_i,
    input  logic [NCH-1:0] tx_rdone_i,
    input  logic [NCH-1:0] rx_rdone_i,
    input  logic           tx_uclk_act_i,
    input  logic           rx_uclk_act_i,
    input  logic           tx_rst_req_i,
    input  logic           rx_rst_req_i,
    output logic           tx_pll_rst_o,
    output logic           tx_dp_rst_o,
    output logic           tx_usr_rdy_o,
    output logic           tx_done_o,
    output logic           tx_byp_start_o,
    output logic           rx_pll_rst_o,
    output logic           rx_dp_rst_o,
    output logic           rx_usr_rdy_o,
    output logic           rx_done_o,
    output logic           rx_byp_start_o
);
    localparam int SW = 5 * NCH + 2;

    logic [NCH-1:0] pg_s, tx_lock_s, rx_lock_s, tx_rdone_s, rx_rdone_s;
    logic           tx_uclk_s, rx_uclk_s;
    logic           pg_ok;
    logic           init_done;
    seq_out_t       tx_out, rx_out;

    xrs_sync #(.W(SW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pwr_good_i, tx_lock_i, rx_lock_i, tx_rdone_i, rx_rdone_i,
               tx_uclk_act_i, rx_uclk_act_i}),
        .q   ({pg_s, tx_lock_s, rx_lock_s, tx_rdone_s, rx_rdone_s,
               tx_uclk_s, rx_uclk_s})
    );

    xrs_pg_hold #(.NCH(NCH), .DLY_EN(PG_DLY_EN), .DLY_CYC(PG_DLY_CYC)) u_pg (
        .clk   (clk),
        .rst   (rst),
        .pg_s  (pg_s),
        .pg_ok (pg_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            init_done <= 1'b0;
        end else if (tx_out.done && rx_out.done) begin
            init_done <= 1'b1;
        end
    end

    xrs_dir_seq #(.TMO_CYC(TMO_CYC), .PLL_RST_CYC(PLL_RST_CYC), .BYPASS(TX_BYPASS)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .start    (pg_ok),
        .req      (tx_rst_req_i && init_done),
        .lock_ok  (&tx_lock_s),
        .uclk_ok  (tx_uclk_s),
        .rdone_ok (&tx_rdone_s),
        .out      (tx_out)
    );

    xrs_dir_seq #(.TMO_CYC(TMO_CYC), .PLL_RST_CYC(PLL_RST_CYC), .BYPASS(RX_BYPASS)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .start    (pg_ok),
        .req      (rx_rst_req_i && init_done),
        .lock_ok  (&rx_lock_s),
        .uclk_ok  (rx_uclk_s),
        .rdone_ok (&rx_rdone_s),
        .out      (rx_out)
    );

    assign tx_pll_rst_o   = tx_out.pll_rst;
    assign tx_dp_rst_o    = tx_out.dp_rst;
    assign tx_usr_rdy_o   = tx_out.usr_rdy;
    assign tx_done_o      = tx_out.done;
    assign tx_byp_start_o = tx_out.byp_start;
    assign rx_pll_rst_o   = rx_out.pll_rst;
    assign rx_dp_rst_o    = rx_out.dp_rst;
    assign rx_usr_rdy_o   = rx_out.usr_rdy;
    assign rx_done_o      = rx_out.done;
    assign rx_byp_start_o = rx_out.byp_start;
endmodule

// File: rtl/xcvr_rst_seq_chk.sv
module xcvr_rst_seq_chk (
    input logic clk,
    input logic rst,
    input logic pg_ok,
    input logic tx_uclk_s,
    input logic rx_uclk_s,
    input logic tx_pll_rst_o,
    input logic tx_dp_rst_o,
    input logic tx_usr_rdy_o,
    input logic tx_done_o,
    input logic tx_byp_start_o,
    input logic rx_pll_rst_o,
    input logic rx_dp_rst_o,
    input logic rx_usr_rdy_o,
    input logic rx_done_o,
    input logic rx_byp_start_o
);
    // R1
    held_before_pg_chk: assert property (@(posedge clk) disable iff (rst)
        !pg_ok |-> (tx_pll_rst_o && rx_pll_rst_o && tx_dp_rst_o && rx_dp_rst_o
                    && !tx_done_o && !rx_done_o));

    // R4
    tx_pll_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_dp_rst_o) |-> !tx_pll_rst_o);

    // R4
    rx_pll_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_dp_rst_o) |-> !rx_pll_rst_o);

    // R5
    tx_ready_clk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_usr_rdy_o) |-> $past(tx_uclk_s));

    // R5
    rx_ready_clk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_usr_rdy_o) |-> $past(rx_uclk_s));

    // R6
    tx_done_state_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done_o |-> (tx_usr_rdy_o && !tx_dp_rst_o && !tx_pll_rst_o));

    // R6
    rx_done_state_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done_o |-> (rx_usr_rdy_o && !rx_dp_rst_o && !rx_pll_rst_o));

    // R7
    tx_byp_edge_chk: assert property (@(posedge clk) disable iff (rst)
        tx_byp_start_o |-> (tx_done_o && !$past(tx_done_o)));

    // R7
    rx_byp_edge_chk: assert property (@(posedge clk) disable iff (rst)
        rx_byp_start_o |-> (rx_done_o && !$past(rx_done_o)));
endmodule

bind xcvr_rst_seq xcvr_rst_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .pg_ok          (pg_ok),
    .tx_uclk_s      (tx_uclk_s),
    .rx_uclk_s      (rx_uclk_s),
    .tx_pll_rst_o   (tx_pll_rst_o),
    .tx_dp_rst_o    (tx_dp_rst_o),
    .tx_usr_rdy_o   (tx_usr_rdy_o),
    .tx_done_o      (tx_done_o),
    .tx_byp_start_o (tx_byp_start_o),
    .rx_pll_rst_o   (rx_pll_rst_o),
    .rx_dp_rst_o    (rx_dp_rst_o),
    .rx_usr_rdy_o   (rx_usr_rdy_o),
    .rx_done_o      (rx_done_o),
    .rx_byp_start_o (rx_byp_start_o)
);

// File: tb/xcvr_rst_seq_tb.sv
module xcvr_rst_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 3;
    localparam int PG_DLY     = 20;
    localparam int TMO        = 150;
    localparam int PLLC       = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [NCH-1:0] pwr_good = '0;
    logic           tx_uclk = 1'b1, rx_uclk = 1'b1;
    logic           tx_req = 1'b0, rx_req = 1'b0;
    logic [NCH-1:0] tx_unlock = '0, rx_unlock = '0;
    logic [NCH-1:0] tx_rd_hold = '0, rx_rd_hold = '0;

    logic tx_pll_rst, tx_dp_rst, tx_usr_rdy, tx_done, tx_byp;
    logic rx_pll_rst, rx_dp_rst, rx_usr_rdy, rx_done, rx_byp;

    // simple PLL and primitive handshake models
    logic tx_lk = 1'b0, rx_lk = 1'b0, tx_rd = 1'b0, rx_rd = 1'b0;
    int   tx_lc = 0, rx_lc = 0, tx_rc = 0, rx_rc = 0;

    always @(posedge clk) begin
        if (tx_pll_rst) begin tx_lc <= 0; tx_lk <= 1'b0; end
        else if (tx_lc < 5) tx_lc <= tx_lc + 1;
        else tx_lk <= 1'b1;
        if (rx_pll_rst) begin rx_lc <= 0; rx_lk <= 1'b0; end
        else if (rx_lc < 5) rx_lc <= rx_lc + 1;
        else rx_lk <= 1'b1;
        if (tx_dp_rst || !tx_usr_rdy) begin tx_rc <= 0; tx_rd <= 1'b0; end
        else if (tx_rc < 4) tx_rc <= tx_rc + 1;
        else tx_rd <= 1'b1;
        if (rx_dp_rst || !rx_usr_rdy) begin rx_rc <= 0; rx_rd <= 1'b0; end
        else if (rx_rc < 4) rx_rc <= rx_rc + 1;
        else rx_rd <= 1'b1;
    end

    xcvr_rst_seq #(
        .NCH(NCH), .PG_DLY_EN(1'b1), .PG_DLY_CYC(PG_DLY), .TMO_CYC(TMO),
        .PLL_RST_CYC(PLLC), .TX_BYPASS(1'b1), .RX_BYPASS(1'b1)
    ) u_dut (
        .clk            (clk),
        .rst            (rst),
        .pwr_good_i     (pwr_good),
        .tx_lock_i      ({NCH{tx_lk}} & ~tx_unlock),
        .rx_lock_i      ({NCH{rx_lk}} & ~rx_unlock),
        .tx_rdone_i     ({NCH{tx_rd}} & ~tx_rd_hold),
        .rx_rdone_i     ({NCH{rx_rd}} & ~rx_rd_hold),
        .tx_uclk_act_i  (tx_uclk),
        .rx_uclk_act_i  (rx_uclk),
        .tx_rst_req_i   (tx_req),
        .rx_rst_req_i   (rx_req),
        .tx_pll_rst_o   (tx_pll_rst),
        .tx_dp_rst_o    (tx_dp_rst),
        .tx_usr_rdy_o   (tx_usr_rdy),
        .tx_done_o      (tx_done),
        .tx_byp_start_o (tx_byp),
        .rx_pll_rst_o   (rx_pll_rst),
        .rx_dp_rst_o    (rx_dp_rst),
        .rx_usr_rdy_o   (rx_usr_rdy),
        .rx_done_o      (rx_done),
        .rx_byp_start_o (rx_byp)
    );

    int tests = 0, fails = 0;
    int tx_byp_n = 0, rx_byp_n = 0, rx_pll_rises = 0;
    logic rx_pll_prev = 1'b1;

    always @(negedge clk) begin
        if (tx_byp) tx_byp_n <= tx_byp_n + 1;
        if (rx_byp) rx_byp_n <= rx_byp_n + 1;
        if (rx_pll_rst && !rx_pll_prev) rx_pll_rises <= rx_pll_rises + 1;
        rx_pll_prev <= rx_pll_rst;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tx;
        tx_req = 1'b1; cyc(1); tx_req = 1'b0;
    endtask

    task automatic pulse_rx;
        rx_req = 1'b1; cyc(1); rx_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int tb0;
        cyc(4);
        rst = 1'b0;
        cyc(2);
        // R1 reset state
        chk(tx_pll_rst && rx_pll_rst && tx_dp_rst && rx_dp_rst && !tx_done && !rx_done,
            "R1 reset state", {tx_pll_rst, rx_pll_rst, tx_dp_rst, rx_dp_rst}, 15);

        // R1 sweep of every incomplete power-good pattern, R9 early requests ignored
        for (int p = 0; p < (1 << NCH) - 1; p++) begin
            pwr_good = NCH'(p);
            cyc(2 * PG_DLY);
            pulse_tx;
            pulse_rx;
            cyc(4);
            chk(tx_pll_rst && rx_pll_rst && tx_dp_rst && rx_dp_rst,
                "R1 partial power held", {tx_pll_rst, rx_pll_rst, tx_dp_rst, rx_dp_rst}, 15);
            chk(!tx_usr_rdy && !rx_usr_rdy && !tx_done && !rx_done,
                "R1 no ready/done", {tx_usr_rdy, rx_usr_rdy, tx_done, rx_done}, 0);
        end

        // R2 settling delay
        pwr_good = '1;
        cyc(PG_DLY);
        chk(tx_pll_rst && rx_pll_rst, "R2 still held in delay", {tx_pll_rst, rx_pll_rst}, 3);
        cyc(PLLC + 8);
        chk(!tx_pll_rst && !rx_pll_rst, "R2 PLL reset released", {tx_pll_rst, rx_pll_rst}, 0);

        // R3 automatic power-up reset
        for (int i = 0; i < 300 && !(tx_done && rx_done); i++) cyc(1);
        chk(tx_done && rx_done, "R3 automatic done", {tx_done, rx_done}, 3);
        chk(!tx_dp_rst && !rx_dp_rst && tx_usr_rdy && rx_usr_rdy,
            "R4 datapath released", {tx_dp_rst, rx_dp_rst}, 0);
        cyc(3);
        // R7 one pulse per completed sequence
        chk(tx_byp_n == 1, "R7 tx bypass pulses", tx_byp_n, 1);
        chk(rx_byp_n == 1, "R7 rx bypass pulses", rx_byp_n, 1);

        // R9 rx request after init: only rx reruns
        pulse_rx;
        cyc(1);
        chk(!rx_done && rx_pll_rst, "R9 rx restarted", {rx_done, rx_pll_rst}, 1);
        tb0 = 0;
        for (int i = 0; i < 300 && !rx_done; i++) begin
            if (!tx_done) tb0++;
            cyc(1);
        end
        chk(tb0 == 0, "R9 tx undisturbed", tb0, 0);
        chk(rx_done, "R9 rx done again", rx_done, 1);
        cyc(2);
        chk(rx_byp_n == 2, "R7 rx second pulse", rx_byp_n, 2);

        // R5 user clocks not active
        tx_uclk = 1'b0;
        pulse_tx;
        cyc(50);
        chk(!tx_usr_rdy && !tx_done && !tx_dp_rst, "R5 ready held without clocks",
            {tx_usr_rdy, tx_done, tx_dp_rst}, 0);
        tx_uclk = 1'b1;
        for (int i = 0; i < 300 && !tx_done; i++) cyc(1);
        chk(tx_done && tx_usr_rdy, "R5 done after clocks active", {tx_done, tx_usr_rdy}, 3);

        // R6 one channel's reset-done withheld
        rx_rd_hold = 3'b010;
        pulse_rx;
        cyc(50);
        chk(rx_usr_rdy && !rx_done, "R6 done waits for all channels", {rx_usr_rdy, rx_done}, 2);
        rx_rd_hold = '0;
        for (int i = 0; i < 300 && !rx_done; i++) cyc(1);
        chk(rx_done, "R6 done after all channels", rx_done, 1);

        // R8 lock loss on one tx channel
        tx_unlock = 3'b100;
        cyc(5);
        chk(!tx_done && !tx_pll_rst, "R8 done drops, no reset", {tx_done, tx_pll_rst}, 0);
        cyc(2 * TMO);
        chk(!tx_done && !tx_pll_rst, "R8 no automatic restart", {tx_done, tx_pll_rst}, 0);
        tx_unlock = '0;
        cyc(20);
        chk(!tx_done, "R8 lock return alone does not restore done", tx_done, 0);
        pulse_tx;
        for (int i = 0; i < 300 && !tx_done; i++) cyc(1);
        chk(tx_done, "R8 request restores done", tx_done, 1);

        // R10 lock never arrives: timeout restarts sequence
        rx_unlock = 3'b001;
        cyc(5);
        rx_pll_rises = 0;
        pulse_rx;
        cyc(TMO + 40);
        chk(rx_pll_rises >= 2, "R10 timeout reasserts PLL reset", rx_pll_rises, 2);
        rx_unlock = '0;
        for (int i = 0; i < 600 && !rx_done; i++) cyc(1);
        chk(rx_done && tx_done, "R10 recovers after lock", {rx_done, tx_done}, 3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule